// File: doc/BRIEF.md
# Phase-Accumulator Variable-Frequency Generator

This block produces a variable-frequency square wave from a fixed reference clock. A 16-bit control word selects a step size. On every reference cycle while the block is running, the step is added to a 16-bit phase register. The top bit of that register is the waveform output. A single-cycle pulse marks each rising edge of the waveform. A downstream fixed-ratio pulse generator uses that pulse as its clock enable.

The step taken from the control word has two ranges:

- In the lower half of the code space, the step is the control word itself.
- In the upper half, the step is the 16-bit two's complement of the control word.

The output frequency is therefore step × 2^-16 × f_ref. When the block feeds the downstream generator, software restricts the word to the range 1 to 32768. A power-of-two word inside that range gives an exact half-high, half-low square wave.

A three-state controller sequences the phase register:

- **IDLE**: run enable is low, and the register is cleared.
- **RUN**: run enable is high and the step is non-zero, so the step is added each cycle.
- **HOLD**: run enable is high and the step is zero, so the register keeps its value.

The transitions are:

- **start**: IDLE to RUN.
- **start_zero**: IDLE to HOLD.
- **freeze**: RUN to HOLD, when the step becomes zero.
- **resume**: HOLD to RUN, when the step becomes non-zero.
- **stop**: any state to IDLE, when run enable falls.

The controller decides the next state from the current inputs. The phase register therefore acts on the same edge at which the inputs are presented.

Top module: `nco_freq_gen`

## Requirements
- R1: The step equals ctrl_word when ctrl_word < 16'h8000. Otherwise the step is (2^16 - ctrl_word) mod 2^16, so 16'h8000 gives 16'h8000 and 16'hF000 gives 16'h1000.
- R2: On each clock edge with run_en high, the 16-bit phase register advances by the step, modulo 2^16. wave_out is bit 15 of the phase register.
- R3: A power-of-two word 2^k (k = 0..15) gives a wave with period 2^(16-k) cycles, exactly half of them high.
- R4: tick_out is high for exactly one cycle each time wave_out goes from 0 to 1, and is never high on two consecutive cycles.
- R5: An edge with run_en low clears the phase register, so wave_out and tick_out are low afterwards.
- R6: A step of zero with run_en high keeps the phase register unchanged, so wave_out holds its value and no tick occurs.
- R7: A change of ctrl_word applies at the next edge and continues from the current phase, without restarting it.
- R8: After reset, wave_out and tick_out are 0.
- R9: The first enabled edge after IDLE leaves the phase register equal to one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low clears the phase |
| ctrl_word | input | 16 | Frequency control word |
| wave_out | output | 1 | Variable-frequency waveform (phase MSB) |
| tick_out | output | 1 | One-cycle pulse on each rising wave edge |

## Verification
Both outputs come directly from registers that the edge following the presented inputs loads, so each result is due one edge after its stimulus. The bench drives inputs on the falling clock edge and samples outputs on the next falling edge, half a period after the rising edge that acts on them. Long runs count the high cycles and ticks over a fixed window of 256 edges. A per-cycle software phase model is compared against the outputs every cycle.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int ACC_W = 16;

    typedef enum logic [1:0] {
        NCO_IDLE = 2'd0,
        NCO_RUN  = 2'd1,
        NCO_HOLD = 2'd2
    } nco_state_e;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_ADD   = 2'd1,
        OP_KEEP  = 2'd2
    } acc_op_e;
endpackage

// File: rtl/nco_incr_map.sv
module nco_incr_map #(
    parameter int W = 16
) (
    input  logic [W-1:0] word_i,
    output logic [W-1:0] incr_o
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    // Lower half passes through; upper half folds to its two's complement.
    always_comb begin
        if (word_i < HALF) begin
            incr_o = word_i;
        end else begin
            incr_o = ~word_i + {{(W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl
    import nco_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run_en,
    input  logic    step_zero,
    output acc_op_e op_o
);
    nco_state_e state_q;
    nco_state_e state_d;

    // Next-state decision uses current inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NCO_IDLE: begin
                if (run_en) state_d = step_zero ? NCO_HOLD : NCO_RUN;
            end
            NCO_RUN: begin
                if (!run_en)       state_d = NCO_IDLE;
                else if (step_zero) state_d = NCO_HOLD;
            end
            NCO_HOLD: begin
                if (!run_en)        state_d = NCO_IDLE;
                else if (!step_zero) state_d = NCO_RUN;
            end
            default: state_d = NCO_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NCO_IDLE;
        else        state_q <= state_d;
    end

    // Output decode: the operation follows the state being entered.
    always_comb begin
        op_o = OP_CLEAR;
        unique case (state_d)
            NCO_IDLE: op_o = OP_CLEAR;
            NCO_RUN:  op_o = OP_ADD;
            NCO_HOLD: op_o = OP_KEEP;
            default:  op_o = OP_CLEAR;
        endcase
    end

    // R5: leaving run enable low always lands in IDLE.
    p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> state_q == NCO_IDLE);
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_op_e      op_i,
    input  logic [W-1:0] incr_i,
    output logic [W-1:0] acc_o
);
    logic [W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            unique case (op_i)
                OP_CLEAR: acc_q <= '0;
                OP_ADD:   acc_q <= acc_q + incr_i;
                OP_KEEP:  acc_q <= acc_q;
                default:  acc_q <= '0;
            endcase
        end
    end

    assign acc_o = acc_q;

    // R2: an add step advances the phase by the step, modulo 2^W.
    p_add_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_ADD |=> acc_q == $past(acc_q) + $past(incr_i));

    // R6: a hold step leaves the phase untouched.
    p_hold_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_KEEP |=> $stable(acc_q));
endmodule

// File: rtl/nco_edge_tick.sv
module nco_edge_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic msb_i,
    output logic tick_o
);
    logic msb_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msb_prev_q <= 1'b0;
        else        msb_prev_q <= msb_i;
    end

    assign tick_o = msb_i & ~msb_prev_q;

    // R4: a tick never lasts longer than one cycle.
    p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/nco_freq_gen.sv
module nco_freq_gen
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [ACC_W-1:0]  ctrl_word,
    output logic              wave_out,
    output logic              tick_out
);
    localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] phase;
    acc_op_e          op;

    nco_incr_map #(.W(ACC_W)) u_map (
        .word_i (ctrl_word),
        .incr_o (step)
    );

    nco_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .step_zero (step == '0),
        .op_o      (op)
    );

    nco_phase_acc #(.W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .incr_i (step),
        .acc_o  (phase)
    );

    assign wave_out = phase[ACC_W-1];

    nco_edge_tick u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .msb_i  (wave_out),
        .tick_o (tick_out)
    );

    // R1: the folded step never exceeds half the phase range.
    p_step_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step <= HALF);

    // R5: an edge with run enable low leaves both outputs low.
    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !wave_out && !tick_out);

    // R6: a zero word while running keeps the waveform level.
    p_zero_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && ctrl_word == '0 |=> $stable(wave_out) && !tick_out);
endmodule

// File: tb/nco_freq_gen_tb.sv
module nco_freq_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int WIN = 256;

    // ctrl word, expected high cycles, expected ticks over WIN edges from phase 0
    localparam logic [15:0] V_WORD [NV] = '{16'h8000, 16'h0100, 16'h1000, 16'hF000,
                                             16'h0003, 16'h0000, 16'hC000, 16'h0001};
    localparam int V_HIGH [NV] = '{128, 128, 128, 128, 0, 0, 128, 0};
    localparam int V_TICK [NV] = '{128,   1,  16,  16, 0, 0,  64, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [15:0] ctrl_word = 16'h0;
    logic        wave_out;
    logic        tick_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] model;

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_freq_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .ctrl_word (ctrl_word),
        .wave_out  (wave_out),
        .tick_out  (tick_out)
    );

    function automatic logic [15:0] step_of(input logic [15:0] w);
        return (w < 16'h8000) ? w : 16'(17'h10000 - {1'b0, w});
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step_clk();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        run_en = 1'b0;
        step_clk();
        step_clk();
        model = 16'h0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model = 16'h0;
        @(negedge clk);
        @(negedge clk);
        // R8: reset state
        check("R8 wave", int'(wave_out), 0);
        check("R8 tick", int'(tick_out), 0);
        rst_n = 1'b1;
        step_clk();

        // Table walk: R1, R2, R3, R4, R6
        for (int v = 0; v < NV; v++) begin
            int hi;
            int tk;
            int dbl;
            int mism;
            logic prev_t;
            hi = 0; tk = 0; dbl = 0; mism = 0; prev_t = 1'b0;
            go_idle();
            check("R5 idle wave", int'(wave_out), 0);
            ctrl_word = V_WORD[v];
            run_en = 1'b1;
            for (int c = 0; c < WIN; c++) begin
                logic exp_w;
                logic prev_w;
                prev_w = model[15];
                step_clk();
                model = model + step_of(ctrl_word);
                exp_w = model[15];
                if (wave_out) hi++;
                if (tick_out) tk++;
                if (tick_out && prev_t) dbl++;
                prev_t = tick_out;
                if (wave_out != exp_w || tick_out != (exp_w && !prev_w)) mism++;
            end
            check($sformatf("R3 high count word %h", V_WORD[v]), hi, V_HIGH[v]);
            check($sformatf("R4 tick count word %h", V_WORD[v]), tk, V_TICK[v]);
            check("R4 no back-to-back ticks", dbl, 0);
            check($sformatf("R2 model match word %h (R1 step)", V_WORD[v]), mism, 0);
        end

        // R9: first edge after idle gives one step: 0x9000 -> step 0x7000
        go_idle();
        ctrl_word = 16'h9000;
        run_en = 1'b1;
        step_clk();
        check("R9 first edge wave (phase 7000)", int'(wave_out), 0);
        step_clk();
        check("R9 second edge wave (phase E000)", int'(wave_out), 1);
        check("R4 tick on rise", int'(tick_out), 1);
        step_clk();
        check("R4 tick drops", int'(tick_out), 0);

        // R6 + R7: freeze with zero word, then resume from held phase
        go_idle();
        ctrl_word = 16'h4000;
        run_en = 1'b1;
        step_clk(); step_clk(); step_clk();
        check("R6 pre-freeze wave (phase C000)", int'(wave_out), 1);
        ctrl_word = 16'h0000;
        begin
            int chg;
            int tk;
            chg = 0; tk = 0;
            for (int c = 0; c < 20; c++) begin
                step_clk();
                if (wave_out != 1'b1) chg++;
                if (tick_out) tk++;
            end
            check("R6 wave held", chg, 0);
            check("R6 no ticks while frozen", tk, 0);
        end
        ctrl_word = 16'h4000;
        step_clk();
        check("R7 resume phase 0000 wave", int'(wave_out), 0);
        step_clk();
        check("R7 phase kept (4000 not 8000)", int'(wave_out), 0);
        step_clk();
        check("R7 phase 8000 wave", int'(wave_out), 1);
        check("R7 tick at 8000", int'(tick_out), 1);

        // R7: mid-run word changes against model, non-power steps
        go_idle();
        run_en = 1'b1;
        begin
            int mism;
            logic prev_w;
            mism = 0;
            for (int c = 0; c < 600; c++) begin
                ctrl_word = (c < 200) ? 16'h3000 : (c < 400) ? 16'h0F00 : 16'hD000;
                prev_w = model[15];
                step_clk();
                model = model + step_of(ctrl_word);
                if (wave_out != model[15] || tick_out != (model[15] && !prev_w)) mism++;
            end
            check("R7 word change keeps phase", mism, 0);
        end

        // R5: drop run enable while wave high
        ctrl_word = 16'h8000;
        step_clk();
        model = model + 16'h8000;
        if (!wave_out) begin
            step_clk();
        end
        check("R5 wave high before stop", int'(wave_out), 1);
        run_en = 1'b0;
        step_clk();
        check("R5 wave low after stop", int'(wave_out), 0);
        check("R5 tick low after stop", int'(tick_out), 0);
        ctrl_word = 16'h2000;
        run_en = 1'b1;
        step_clk(); step_clk(); step_clk(); step_clk();
        check("R9 restart from zero (phase 8000 after 4)", int'(wave_out), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule